// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits beside a synchronous DRAM controller and owns the refresh duty. A free-running interval timer, whose reload is worked out from the clock period and the average refresh spacing, adds one unit of refresh debt each time it expires. The controller sees a refresh request while any debt is outstanding. It may postpone that request while host traffic is pending, up to a small credit limit. When it grants the command bus, the scheduler closes any open rows with a precharge-all command, waits the precharge time and issues one auto refresh. It then keeps the bus for the refresh cycle time.

When the debt reaches its ceiling, an urgent flag is raised and the scheduler starts the sequence without waiting for a grant. A low-power request made with a grant puts the memory into self-refresh: the refresh encoding is driven with the clock enable taken low, and the clock enable stays low for as long as the request is held. Dropping the request raises the clock enable again. The bus stays blocked for one refresh cycle time after exit, and any debt still owed is cleared.

While it owns the bus (busy high), the block drives the command pins. When busy is low, the controller's own commands go to the memory. Timing values are given in picoseconds and converted to whole clocks, with rounding up for the wait times.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted: cke is 1, busy is 0, debt is 0, ref_req is 0, ref_urgent is 0, and cs_n is 1 (deselect).
- R2: The debt rises by one every REFI_CYC = REFI_PS/CLK_PS clocks, counted from reset release, so the first increment is seen after REFI_CYC rising edges. ref_req is 1 whenever debt is nonzero.
- R3: ref_urgent is 1 once debt equals DEBT_MAX, and debt never exceeds DEBT_MAX.
- R4: With debt nonzero, grant sampled high and bank_open low, the cycle after the grant carries auto refresh: cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. The next cycle shows debt one lower, plus one if a timer increment landed on that edge.
- R5: If bank_open is high when the sequence starts, the first command is precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1). The following command comes exactly TRP_CYC clocks later (TRP_PS rounded up to clocks, at least 2), with NOP cycles in between (cs_n=0, ras_n=cas_n=we_n=1).
- R6: After an auto refresh at cycle t, busy stays high with NOP through cycle t+TRRC_CYC-1 and is low at t+TRRC_CYC, where TRRC_CYC is TRRC_PS rounded up to clocks, at least 2.
- R7: With ref_urgent high and busy low, the sequence starts on the next cycle even when grant is low.
- R8: Self-refresh entry drives the auto refresh encoding with cke=0 in the same cycle. cke then stays 0 with NOP for as long as sr_req is held, and debt does not change during that time.
- R9: The cycle after sr_req is seen low in self-refresh, cke is 1, busy is 1, debt is 0 and ref_req is 0. busy stays high for TRRC_CYC cycles counting that first cycle.
- R10: With grant low, ref_urgent low and busy low, busy stays low in the next cycle and no command is driven.
- R11: When sr_req and grant are both high while refresh debt is pending, self-refresh entry takes priority over the auto refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | Controller hands the command bus to the scheduler |
| bank_open | input | 1 | At least one bank has an active row |
| sr_req | input | 1 | Low-power request; held high to stay in self-refresh |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; high selects all banks on precharge |
| busy | output | 1 | Scheduler owns the bus; controller must hold off |
| ref_req | output | 1 | Refresh debt is outstanding |
| ref_urgent | output | 1 | Debt at its ceiling; sequence starts without grant |
| debt | output | $clog2(DEBT_MAX+1) | Refreshes owed |

## Verification
The bench checks the exact clock of each command relative to the grant. A design that skips the precharge wait, or sends the refresh one cycle early, puts the wrong code on the pins in the sampled cycle. The bench follows the debt across a refresh while accounting for timer increments that land on the same edge, so a lost or doubled decrement is caught. It checks that saturation starts a sequence with no grant, so a design that still waits for the grant never shows the precharge. It checks that self-refresh wins over a pending refresh, that cke stays low with the debt frozen, and that the exit blackout lasts the full refresh cycle time with the debt cleared. A design that lets the timer run in self-refresh, or ends the blackout one cycle early, fails these checks.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_PS   = 10000,
  parameter int REFI_PS  = 15625000,
  parameter int TRP_PS   = 20000,
  parameter int TRRC_PS  = 70000,
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic bank_open,
  input  logic sr_req,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10,
  output logic busy,
  output logic ref_req,
  output logic ref_urgent,
  output logic [$clog2(DEBT_MAX+1)-1:0] debt
);
  localparam int REFI_RAW = REFI_PS / CLK_PS;
  localparam int REFI_CYC = (REFI_RAW < 2) ? 2 : REFI_RAW;
  localparam int TRP_RAW  = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRP_CYC  = (TRP_RAW < 2) ? 2 : TRP_RAW;
  localparam int TRRC_RAW = (TRRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRRC_CYC = (TRRC_RAW < 2) ? 2 : TRRC_RAW;
  localparam int WMAX     = (TRP_CYC > TRRC_CYC) ? TRP_CYC : TRRC_CYC;
  localparam int TW       = $clog2(REFI_CYC);
  localparam int WW       = $clog2(WMAX + 1);
  localparam int DW       = $clog2(DEBT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_WRP, S_REF, S_WRC, S_SRE, S_SELF, S_SRX
  } state_t;

  state_t        state;
  logic [WW-1:0] wcnt;
  logic [TW-1:0] tcnt;
  logic          to_self;

  wire frozen  = (state == S_SRE) || (state == S_SELF);
  wire tick    = (tcnt == '0) && !frozen;
  wire ref_now = (state == S_REF);
  wire sr_exit = (state == S_SELF) && !sr_req;
  wire at_max  = (debt == DW'(DEBT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tcnt <= TW'(REFI_CYC - 1);
    else if (frozen || tcnt == '0) tcnt <= TW'(REFI_CYC - 1);
    else                           tcnt <= tcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              debt <= '0;
    else if (sr_exit)                        debt <= '0;
    else if (tick && !ref_now && !at_max)    debt <= debt + 1'b1;
    else if (!tick && ref_now)               debt <= debt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wcnt    <= '0;
      to_self <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (sr_req && grant) begin
            to_self <= 1'b1;
            state   <= bank_open ? S_PRE : S_SRE;
          end else if (ref_urgent || (ref_req && grant)) begin
            to_self <= 1'b0;
            state   <= bank_open ? S_PRE : S_REF;
          end
        end
        S_PRE: begin
          state <= S_WRP;
          wcnt  <= WW'(TRP_CYC - 2);
        end
        S_WRP: begin
          if (wcnt == '0) state <= to_self ? S_SRE : S_REF;
          else            wcnt  <= wcnt - 1'b1;
        end
        S_REF: begin
          state <= S_WRC;
          wcnt  <= WW'(TRRC_CYC - 2);
        end
        S_WRC: begin
          if (wcnt == '0) state <= S_IDLE;
          else            wcnt  <= wcnt - 1'b1;
        end
        S_SRE:  state <= S_SELF;
        S_SELF: begin
          if (!sr_req) begin
            state <= S_SRX;
            wcnt  <= WW'(TRRC_CYC - 1);
          end
        end
        S_SRX: begin
          if (wcnt == '0) state <= S_IDLE;
          else            wcnt  <= wcnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire is_pre = (state == S_PRE);
  wire is_ref = (state == S_REF) || (state == S_SRE);

  assign busy       = (state != S_IDLE);
  assign cke        = !frozen;
  assign cs_n       = !busy;
  assign ras_n      = !(is_pre || is_ref);
  assign cas_n      = !is_ref;
  assign we_n       = !is_pre;
  assign a10        = is_pre;
  assign ref_req    = (debt != '0);
  assign ref_urgent = at_max;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int CLK_PS   = 10000,
  parameter int TRP_PS   = 20000,
  parameter int TRRC_PS  = 70000,
  parameter int DEBT_MAX = 8
) (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic busy,
  input logic ref_urgent,
  input logic [$clog2(DEBT_MAX+1)-1:0] debt
);
  localparam int TRP_RAW  = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRP_CYC  = (TRP_RAW < 2) ? 2 : TRP_RAW;
  localparam int TRRC_RAW = (TRRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRRC_CYC = (TRRC_RAW < 2) ? 2 : TRRC_RAW;

  wire any_cmd = !cs_n && !(ras_n && cas_n && we_n);
  wire pre_cmd = !cs_n && !ras_n && cas_n && !we_n;
  wire ref_cmd = !cs_n && !ras_n && !cas_n && we_n;

  logic [15:0] since_pre, since_ref;
  logic        cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= 16'hFFFF;
      since_ref <= 16'hFFFF;
      cke_q     <= 1'b1;
    end else begin
      cke_q     <= cke;
      since_pre <= pre_cmd ? 16'd1 :
                   (since_pre == 16'hFFFF) ? since_pre : since_pre + 16'd1;
      since_ref <= ((ref_cmd && cke) || (cke && !cke_q)) ? 16'd1 :
                   (since_ref == 16'hFFFF) ? since_ref : since_ref + 16'd1;
    end
  end

  p_debt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(debt) <= DEBT_MAX);

  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cmd |-> a10);

  p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> (since_pre >= 16'(TRP_CYC)));

  p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> (since_ref >= 16'(TRRC_CYC)));

  p_urgent_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && !busy) |=> busy);

  p_sr_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ref_cmd);

  p_sr_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (busy && debt == '0));

  p_stay_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !grant && !ref_urgent) |=> !busy);
endmodule

bind refresh_sched refresh_sched_chk #(
  .CLK_PS(CLK_PS), .TRP_PS(TRP_PS), .TRRC_PS(TRRC_PS), .DEBT_MAX(DEBT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .cke(cke), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10), .busy(busy),
  .ref_urgent(ref_urgent), .debt(debt)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int CLK_NS   = 10;
  localparam int CLK_PS   = CLK_NS * 1000;
  localparam int REFI_PS  = 400000;
  localparam int TRP_PS   = 25000;
  localparam int TRRC_PS  = 60000;
  localparam int DEBT_MAX = 8;
  localparam int REFI     = REFI_PS / CLK_PS;
  localparam int TRP      = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRRC     = (TRRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int DW       = $clog2(DEBT_MAX + 1);

  localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_SRE = 3;

  // {bank_open, expected first command}
  localparam int VEC [4][2] = '{'{0, C_REF}, '{1, C_PRE}, '{1, C_PRE}, '{0, C_REF}};

  logic clk = 1'b0, rst_n, grant, bank_open, sr_req;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, busy, ref_req, ref_urgent;
  logic [DW-1:0] debt;
  int checks = 0, errors = 0, cyc = 0;

  refresh_sched #(.CLK_PS(CLK_PS), .REFI_PS(REFI_PS), .TRP_PS(TRP_PS),
                  .TRRC_PS(TRRC_PS), .DEBT_MAX(DEBT_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .bank_open(bank_open), .sr_req(sr_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .busy(busy), .ref_req(ref_req), .ref_urgent(ref_urgent), .debt(debt));

  always #(CLK_NS / 2) clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic int code();
    if (cs_n || (ras_n && cas_n && we_n)) return C_NOP;
    if (!ras_n && cas_n && !we_n && a10)  return C_PRE;
    if (!ras_n && !cas_n && we_n)         return cke ? C_REF : C_SRE;
    return 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, bad, lim;
    rst_n = 1'b0; grant = 1'b0; bank_open = 1'b0; sr_req = 1'b0;
    repeat (3) step();
    chk("R1 cke", cke, 1);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 debt", int'(debt), 0);
    chk("R1 req", ref_req + 2 * ref_urgent, 0);
    rst_n = 1'b1;

    repeat (REFI - 1) step();
    chk("R2 before tick", int'(debt), 0);
    step();
    chk("R2 first tick", int'(debt), 1);
    chk("R2 ref_req", ref_req, 1);
    repeat (REFI) step();
    chk("R2 second tick", int'(debt), 2);

    bad = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (busy || code() != C_NOP) bad++;
    end
    chk("R10 no grant no command", bad, 0);

    lim = 0;
    while (int'(debt) != DEBT_MAX && lim < 10 * REFI) begin step(); lim++; end
    chk("R3 urgent at max", ref_urgent, 1);
    chk("R7 still idle", busy, 0);
    bank_open = 1'b1;
    step();
    chk("R7 starts without grant", code(), C_PRE);
    bad = 0;
    for (int k = 1; k < TRP; k++) begin step(); if (code() != C_NOP) bad++; end
    chk("R5 nop gap", bad, 0);
    step();
    chk("R5 ref after trp", code(), C_REF);
    step();
    chk("R3 debt after refresh", int'(debt), DEBT_MAX - 1);
    chk("R3 urgent cleared", ref_urgent, 0);
    repeat (TRRC - 2) step();
    chk("R6 busy in blackout", busy, 1);
    step();
    chk("R6 idle after trrc", busy, 0);

    for (int i = 0; i < 4; i++) begin
      bank_open = VEC[i][0][0];
      grant = 1'b1;
      step();
      grant = 1'b0;
      chk("R4 R5 first command", code(), VEC[i][1]);
      if (VEC[i][0] != 0) begin
        bad = 0;
        for (int k = 1; k < TRP; k++) begin step(); if (code() != C_NOP) bad++; end
        chk("R5 nop gap", bad, 0);
        step();
        chk("R5 ref after trp", code(), C_REF);
      end
      d = int'(debt);
      step();
      chk("R4 debt decrement", int'(debt), d - 1 + ((cyc % REFI == 0) ? 1 : 0));
      repeat (TRRC - 2) step();
      chk("R6 busy in blackout", busy, 1);
      step();
      chk("R6 idle after trrc", busy, 0);
    end

    bank_open = 1'b0; sr_req = 1'b1; grant = 1'b1;
    step();
    grant = 1'b0;
    chk("R11 self refresh wins", code(), C_SRE);
    chk("R8 cke low at entry", cke, 0);
    d = int'(debt);
    bad = 0;
    for (int k = 0; k < 3 * REFI; k++) begin
      step();
      if (cke || code() != C_NOP) bad++;
    end
    chk("R8 cke held low", bad, 0);
    chk("R8 debt frozen", int'(debt), d);
    sr_req = 1'b0;
    step();
    chk("R9 cke high", cke, 1);
    chk("R9 busy on exit", busy, 1);
    chk("R9 debt cleared", int'(debt), 0);
    chk("R9 no request", ref_req, 0);
    repeat (TRRC - 1) step();
    chk("R9 blackout end", busy, 1);
    step();
    chk("R9 released", busy, 0);

    bank_open = 1'b1; sr_req = 1'b1; grant = 1'b1;
    step();
    grant = 1'b0;
    chk("R8 precharge before entry", code(), C_PRE);
    repeat (TRP - 1) step();
    step();
    chk("R8 entry after trp", code(), C_SRE);
    step();
    sr_req = 1'b0;
    step();
    chk("R9 cke high", cke, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule